// File: doc/BRIEF.md
# Host Bus Burst Memory Write Port

This block is the write side of a slave port for an 8080-style parallel host bus. The bus has a chip select, a command/data select line, a 16-bit data bus and two write strobes, one for each byte lane. A command cycle (select line low) carries an 8-bit register index. A data cycle (select line high) carries either a register value or, when a burst is armed, data for an embedded memory. The block drives a simple synchronous write port toward that memory: a byte address, 16-bit data, a two-bit byte enable and a one-cycle write pulse.

Bus inputs pass through a synchronizer into the core clock domain. A cycle decoder has three states: `CY_IDLE`, `CY_STROBE` and `CY_DONE`. A qualified strobe (any write strobe low while chip select is low) moves it from `CY_IDLE` to `CY_STROBE`. In `CY_STROBE` it merges the active lanes and keeps the latest data. When both strobes are released it moves to `CY_DONE`, issues the cycle once, and returns to `CY_IDLE`. A burst controller has two states: `BR_OFF` and `BR_ARMED`. A command carrying index 0xC4 moves it to `BR_ARMED` and loads the write pointer from the address register. Any other command moves it to `BR_OFF`.

Software first loads the start address (index 0xC0 for the low byte, 0xC1 for the high byte) and the mode register (index 0xC6), then sends the start command and streams data. Mode bit 0 selects word mode. Mode bit 1 selects big-endian byte order.

Top module: `hbus_burst_port`

## Requirements
- R1: After reset `mem_we` is low and no burst is armed, so data cycles that are not preceded by a 0xC4 command never write memory.
- R2: While no burst is armed, a data cycle stores the low bus byte into the register selected by the last command index: 0xC0 is address bits 7:0, 0xC1 is address bits 15:8, and 0xC6 is the mode register (bit 0 word mode, bit 1 big-endian). Other indices are discarded.
- R3: A command with index 0xC4 arms a burst with no data cycle needed, and loads the write pointer from the address register. A repeated 0xC4 while armed reloads the pointer.
- R4: In word mode every armed data cycle in which the lower strobe is active writes a full word with `mem_be`=11, whatever the upper strobe does. A cycle with only the upper strobe active writes nothing.
- R5: In word mode the pointer advances by 2 after each word.
- R6: For a two-byte write, little-endian order (mode bit 1 = 0) puts bus bits 7:0 in `mem_wdata[7:0]` (address n) and bus bits 15:8 in `mem_wdata[15:8]` (address n+1). Big-endian order swaps the two bytes.
- R7: In byte mode only the strobed lanes are written. A single lane gives `mem_be`=01, with that lane's byte in `mem_wdata[7:0]` and zero in `mem_wdata[15:8]`, and the pointer advances by 1. Both lanes give a two-byte write ordered as in R6, and the pointer advances by 2.
- R8: Any command index other than 0xC4 disarms the burst, and the data cycles that follow go to registers, not memory.
- R9: Strobe pulses while chip select is high have no effect: they do not change registers or burst state, and they write nothing.
- R10: Each accepted memory data cycle gives exactly one `mem_we` pulse one clock wide, even when the two strobes are released in different clocks.
- R11: The pointer wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_dc | input | 1 | 0 = command cycle, 1 = data cycle |
| bus_wr_hi_n | input | 1 | Upper byte lane write strobe, active low |
| bus_wr_lo_n | input | 1 | Lower byte lane write strobe, active low |
| bus_data | input | 16 | Host data bus |
| mem_we | output | 1 | One-cycle memory write pulse |
| mem_addr | output | AW | Byte address n of the write |
| mem_wdata | output | 16 | Bits 7:0 go to address n, bits 15:8 go to n+1 |
| mem_be | output | 2 | Byte enables, bit 0 for address n |

## Verification
Two events can fall in the same clock: the release of the upper strobe and the release of the lower strobe. They must merge into one bus cycle, not two. The bench provokes this by releasing the lower strobe two clocks before the upper one, in both byte mode and word mode. It judges the result by requiring exactly one write, with both lanes and a single 2-byte pointer step. A second such pairing is loading the write pointer at the moment the burst arms. The bench covers it by re-issuing the start command while a burst is already armed, then checking that the next write lands at the address register value and not at the running pointer.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = BUS_W / 2;
    localparam int IDX_W  = 8;

    localparam logic [IDX_W-1:0] IDX_ADDR_LO = 8'hC0;
    localparam logic [IDX_W-1:0] IDX_ADDR_HI = 8'hC1;
    localparam logic [IDX_W-1:0] IDX_START   = 8'hC4;
    localparam logic [IDX_W-1:0] IDX_MODE    = 8'hC6;

    localparam int MODE_WORD_BIT = 0;
    localparam int MODE_BE_BIT   = 1;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_STROBE,
        CY_DONE
    } cy_state_t;

    typedef enum logic {
        BR_OFF,
        BR_ARMED
    } br_state_t;

    typedef struct packed {
        logic              is_cmd;
        logic [1:0]        lanes;
        logic [BUS_W-1:0]  data;
    } bus_ev_t;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/hbus_cycle_fsm.sv
module hbus_cycle_fsm
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             dc,
    input  logic             wr_hi_n,
    input  logic             wr_lo_n,
    input  logic [BUS_W-1:0] data,
    output logic             ev_valid,
    output bus_ev_t          ev
);

    cy_state_t  state;
    cy_state_t  state_nx;
    logic [1:0] live;

    // qualified strobes: bit 1 upper lane, bit 0 lower lane
    assign live = {~wr_hi_n, ~wr_lo_n} & {2{~cs_n}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CY_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CY_IDLE:   if (|live)  state_nx = CY_STROBE;
            CY_STROBE: if (!(|live)) state_nx = CY_DONE;
            CY_DONE:   state_nx = CY_IDLE;
            default:   state_nx = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev <= '0;
        end else begin
            unique case (state)
                CY_IDLE: begin
                    if (|live) begin
                        ev.is_cmd <= ~dc;
                        ev.lanes  <= live;
                        ev.data   <= data;
                    end
                end
                CY_STROBE: begin
                    if (|live) begin
                        ev.is_cmd <= ~dc;
                        ev.lanes  <= ev.lanes | live;
                        ev.data   <= data;
                    end
                end
                default: ;
            endcase
        end
    end

    assign ev_valid = (state == CY_DONE);

endmodule

// File: rtl/hbus_steer.sv
module hbus_steer
    import hbus_pkg::*;
(
    input  logic [1:0]       lanes,
    input  logic [BUS_W-1:0] data,
    input  logic             word_mode,
    input  logic             big_endian,
    output logic             accept,
    output logic [1:0]       be,
    output logic [BUS_W-1:0] wdata,
    output logic [1:0]       step
);

    logic [1:0]        lanes_eff;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;

    assign lo_byte = data[BYTE_W-1:0];
    assign hi_byte = data[BUS_W-1:BYTE_W];

    always_comb begin
        if (word_mode) begin
            accept    = lanes[0];
            lanes_eff = 2'b11;
        end else begin
            accept    = |lanes;
            lanes_eff = lanes;
        end

        if (lanes_eff == 2'b11) begin
            be    = 2'b11;
            step  = 2'd2;
            wdata = big_endian ? {lo_byte, hi_byte} : {hi_byte, lo_byte};
        end else begin
            be    = 2'b01;
            step  = 2'd1;
            wdata = {{BYTE_W{1'b0}}, (lanes_eff[0] ? lo_byte : hi_byte)};
        end
    end

endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  bus_ev_t          ev,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [BUS_W-1:0] mem_wdata,
    output logic [1:0]       mem_be,
    output logic             burst_armed,
    output logic             word_mode,
    output logic [AW-1:0]    ptr,
    output logic [15:0]      addr_reg
);

    br_state_t          br_state;
    br_state_t          br_nx;
    logic [IDX_W-1:0]   index;
    logic [1:0]         mode_reg;
    logic               is_start;

    logic               st_accept;
    logic [1:0]         st_be;
    logic [BUS_W-1:0]   st_wdata;
    logic [1:0]         st_step;

    assign is_start = (ev.data[IDX_W-1:0] == IDX_START);

    hbus_steer u_steer (
        .lanes      (ev.lanes),
        .data       (ev.data),
        .word_mode  (mode_reg[MODE_WORD_BIT]),
        .big_endian (mode_reg[MODE_BE_BIT]),
        .accept     (st_accept),
        .be         (st_be),
        .wdata      (st_wdata),
        .step       (st_step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_state <= BR_OFF;
        end else begin
            br_state <= br_nx;
        end
    end

    always_comb begin
        br_nx = br_state;
        unique case (br_state)
            BR_OFF:   if (ev_valid && ev.is_cmd && is_start)  br_nx = BR_ARMED;
            BR_ARMED: if (ev_valid && ev.is_cmd && !is_start) br_nx = BR_OFF;
            default:  br_nx = BR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
            index     <= '0;
            mode_reg  <= '0;
            addr_reg  <= '0;
            ptr       <= '0;
        end else begin
            mem_we <= 1'b0;
            if (ev_valid) begin
                if (ev.is_cmd) begin
                    index <= ev.data[IDX_W-1:0];
                    if (is_start) begin
                        ptr <= addr_reg[AW-1:0];
                    end
                end else if (br_state == BR_ARMED) begin
                    if (st_accept) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= ptr;
                        mem_wdata <= st_wdata;
                        mem_be    <= st_be;
                        ptr       <= ptr + AW'(st_step);
                    end
                end else begin
                    case (index)
                        IDX_ADDR_LO: addr_reg[7:0]  <= ev.data[7:0];
                        IDX_ADDR_HI: addr_reg[15:8] <= ev.data[7:0];
                        IDX_MODE:    mode_reg       <= ev.data[1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    assign burst_armed = (br_state == BR_ARMED);
    assign word_mode   = mode_reg[MODE_WORD_BIT];

endmodule

// File: rtl/hbus_burst_port.sv
module hbus_burst_port
    import hbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_dc,
    input  logic          bus_wr_hi_n,
    input  logic          bus_wr_lo_n,
    input  logic [15:0]   bus_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic [1:0]    mem_be
);

    localparam int SW = BUS_W + 4;
    localparam logic [SW-1:0] SYNC_RST = {4'b1111, {BUS_W{1'b0}}};

    logic [SW-1:0]    raw;
    logic [SW-1:0]    synced;
    logic             s_cs_n;
    logic             s_dc;
    logic             s_wr_hi_n;
    logic             s_wr_lo_n;
    logic [BUS_W-1:0] s_data;

    logic             ev_valid;
    bus_ev_t          ev;

    logic             burst_armed;
    logic             word_mode;
    logic [AW-1:0]    ptr;
    logic [15:0]      addr_reg;

    assign raw = {bus_cs_n, bus_dc, bus_wr_hi_n, bus_wr_lo_n, bus_data};

    hbus_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    assign {s_cs_n, s_dc, s_wr_hi_n, s_wr_lo_n, s_data} = synced;

    hbus_cycle_fsm u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (s_cs_n),
        .dc       (s_dc),
        .wr_hi_n  (s_wr_hi_n),
        .wr_lo_n  (s_wr_lo_n),
        .data     (s_data),
        .ev_valid (ev_valid),
        .ev       (ev)
    );

    hbus_ctrl #(
        .AW (AW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev          (ev),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .burst_armed (burst_armed),
        .word_mode   (word_mode),
        .ptr         (ptr),
        .addr_reg    (addr_reg)
    );

endmodule

// File: rtl/hbus_burst_port_chk.sv
module hbus_burst_port_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_be,
    input logic          burst_armed,
    input logic          word_mode,
    input logic [AW-1:0] ptr,
    input logic [15:0]   addr_reg
);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_be_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 2'b11 || mem_be == 2'b01));

    assert_word_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && word_mode) |-> (mem_be == 2'b11));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ptr == mem_addr + ((mem_be == 2'b11) ? AW'(2) : AW'(1))));

    assert_write_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> burst_armed);

    assert_arm_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_armed) |-> (ptr == addr_reg[AW-1:0]));

endmodule

bind hbus_burst_port hbus_burst_port_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .burst_armed (burst_armed),
    .word_mode   (word_mode),
    .ptr         (ptr),
    .addr_reg    (addr_reg)
);

// File: tb/hbus_burst_port_tb.sv
module hbus_burst_port_tb;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1;
    logic          bus_dc = 1'b1;
    logic          bus_wr_hi_n = 1'b1;
    logic          bus_wr_lo_n = 1'b1;
    logic [15:0]   bus_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [1:0]    mem_be;

    always #5 clk = ~clk;

    hbus_burst_port #(.AW(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs_n   (bus_cs_n),
        .bus_dc     (bus_dc),
        .bus_wr_hi_n(bus_wr_hi_n),
        .bus_wr_lo_n(bus_wr_lo_n),
        .bus_data   (bus_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be)
    );

    int errs = 0;
    int checks = 0;
    int wr_seen = 0;
    bit done = 0;
    bit prev_we = 0;
    string cur_tag = "R1";

    logic [AW-1:0] q_addr[$];
    logic [15:0]   q_data[$];
    logic [1:0]    q_be[$];
    string         q_tag[$];

    // reference state, built from the requirements
    logic [7:0]    m_idx = '0;
    logic [15:0]   m_addr = '0;
    logic [1:0]    m_mode = '0;
    bit            m_armed = 0;
    logic [AW-1:0] m_ptr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void push_wr(input logic [AW-1:0] a, input logic [15:0] d,
                                    input logic [1:0] be);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_be.push_back(be);
        q_tag.push_back(cur_tag);
    endfunction

    function automatic void model(input bit cs_n, input bit dc,
                                  input logic [15:0] d, input logic [1:0] lanes);
        logic [15:0] two;
        if (cs_n || lanes == 2'b00) return;
        if (!dc) begin
            m_idx = d[7:0];
            if (d[7:0] == 8'hC4) begin
                m_armed = 1;
                m_ptr = m_addr[AW-1:0];
            end else begin
                m_armed = 0;
            end
        end else if (m_armed) begin
            two = m_mode[1] ? {d[7:0], d[15:8]} : d;
            if (m_mode[0]) begin
                if (lanes[0]) begin
                    push_wr(m_ptr, two, 2'b11);
                    m_ptr = m_ptr + AW'(2);
                end
            end else if (lanes == 2'b11) begin
                push_wr(m_ptr, two, 2'b11);
                m_ptr = m_ptr + AW'(2);
            end else begin
                push_wr(m_ptr, {8'h00, (lanes[0] ? d[7:0] : d[15:8])}, 2'b01);
                m_ptr = m_ptr + AW'(1);
            end
        end else begin
            case (m_idx)
                8'hC0: m_addr[7:0] = d[7:0];
                8'hC1: m_addr[15:8] = d[7:0];
                8'hC6: m_mode = d[1:0];
                default: ;
            endcase
        end
    endfunction

    task automatic bus_cyc(input bit cs_n, input bit dc, input logic [15:0] d,
                           input logic [1:0] lanes, input bit stagger);
        model(cs_n, dc, d, lanes);
        @(negedge clk);
        bus_cs_n = cs_n;
        bus_dc = dc;
        bus_data = d;
        repeat (3) @(negedge clk);
        bus_wr_lo_n = ~lanes[0];
        bus_wr_hi_n = ~lanes[1];
        repeat (4) @(negedge clk);
        if (stagger) begin
            bus_wr_lo_n = 1'b1;
            repeat (2) @(negedge clk);
        end
        bus_wr_lo_n = 1'b1;
        bus_wr_hi_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (7) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] idx);
        bus_cyc(1'b0, 1'b0, {8'h00, idx}, 2'b01, 1'b0);
    endtask

    task automatic dat(input logic [15:0] d, input logic [1:0] lanes, input bit stagger);
        bus_cyc(1'b0, 1'b1, d, lanes, stagger);
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        cmd(idx);
        dat({8'h00, v}, 2'b01, 1'b0);
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            wr_seen++;
            if (prev_we) begin
                checks++;
                errs++;
                $display("FAIL R10 write pulse longer than one clock: actual=1 expected=0");
            end
            if (q_addr.size() == 0) begin
                checks++;
                errs++;
                $display("FAIL R8 unexpected write: actual addr=%0h data=%0h be=%0b expected none",
                         mem_addr, mem_wdata, mem_be);
            end else begin
                chk(mem_addr == q_addr[0], q_tag[0], "write address", mem_addr, q_addr[0]);
                chk(mem_wdata == q_data[0], q_tag[0], "write data", mem_wdata, q_data[0]);
                chk(mem_be == q_be[0], q_tag[0], "byte enable", mem_be, q_be[0]);
                void'(q_addr.pop_front());
                void'(q_data.pop_front());
                void'(q_be.pop_front());
                void'(q_tag.pop_front());
            end
        end
        prev_we = mem_we;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int snap;
        void'($urandom(32'd5151));
        repeat (5) @(negedge clk);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);

        // R1: data before any arm writes nothing
        cur_tag = "R1";
        dat(16'hBEEF, 2'b11, 1'b0);
        chk(wr_seen == 0, "R1", "writes before arm", wr_seen, 0);

        // R2/R3/R4/R5/R6: word mode, little endian
        set_reg(8'hC0, 8'h34);
        set_reg(8'hC1, 8'h12);
        set_reg(8'hC6, 8'h01);
        cmd(8'hC4);
        cur_tag = "R3";
        dat(16'hA1B2, 2'b11, 1'b0);
        cur_tag = "R4";
        dat(16'hC3D4, 2'b01, 1'b0);
        snap = wr_seen;
        dat(16'h5555, 2'b10, 1'b0);
        chk(wr_seen == snap, "R4", "upper-only strobe in word mode", wr_seen - snap, 0);
        cur_tag = "R5";
        dat(16'hE5F6, 2'b11, 1'b1);

        // R8 disarm then R2 mode change, R3 re-arm, R6 big endian
        cmd(8'hC6);
        snap = wr_seen;
        dat(16'h0003, 2'b01, 1'b0);
        chk(wr_seen == snap, "R8", "data after disarm", wr_seen - snap, 0);
        cmd(8'hC4);
        cur_tag = "R6";
        dat(16'h1122, 2'b11, 1'b0);

        // R9: chip select high pulses
        snap = wr_seen;
        bus_cyc(1'b1, 1'b0, 16'h0000, 2'b11, 1'b0);
        bus_cyc(1'b1, 1'b1, 16'h7777, 2'b11, 1'b0);
        chk(wr_seen == snap, "R9", "pulses without chip select", wr_seen - snap, 0);
        cur_tag = "R9";
        dat(16'h3344, 2'b11, 1'b0);

        // R3: re-arm while armed reloads pointer
        cmd(8'hC4);
        cur_tag = "R3";
        dat(16'h9988, 2'b01, 1'b0);

        // R7: byte mode
        cmd(8'hC6);
        dat(16'h0000, 2'b01, 1'b0);
        cmd(8'hC4);
        cur_tag = "R7";
        dat(16'h5566, 2'b01, 1'b0);
        dat(16'h7788, 2'b10, 1'b0);
        dat(16'h99AA, 2'b11, 1'b0);
        cur_tag = "R10";
        snap = wr_seen;
        dat(16'hBBCC, 2'b11, 1'b1);
        chk(wr_seen == snap + 1, "R10", "staggered release gives one write", wr_seen - snap, 1);

        // R11: wrap
        set_reg(8'hC0, 8'hFF);
        set_reg(8'hC1, 8'hFF);
        set_reg(8'hC6, 8'h01);
        cmd(8'hC4);
        cur_tag = "R11";
        dat(16'h0102, 2'b11, 1'b0);
        dat(16'h0304, 2'b11, 1'b0);

        // R2/R8: other command disarms, data lands in register
        cmd(8'hC1);
        snap = wr_seen;
        dat(16'h0040, 2'b01, 1'b0);
        chk(wr_seen == snap, "R8", "register write while disarmed", wr_seen - snap, 0);
        cmd(8'hC4);
        cur_tag = "R2";
        dat(16'hCAFE, 2'b11, 1'b0);

        // constrained random mix
        cur_tag = "R7";
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [1:0] ln;
            r = $urandom_range(0, 11);
            ln = 2'($urandom_range(1, 3));
            if (r == 0) begin
                cmd(8'hC4);
            end else if (r == 1) begin
                cmd(8'($urandom));
            end else if (r == 2) begin
                case ($urandom_range(0, 2))
                    0: cmd(8'hC0);
                    1: cmd(8'hC1);
                    default: cmd(8'hC6);
                endcase
            end else if (r == 3) begin
                bus_cyc(1'b1, 1'($urandom), 16'($urandom), ln, 1'b0);
            end else begin
                dat(16'($urandom), ln, 1'($urandom));
            end
        end

        repeat (20) @(negedge clk);
        chk(q_addr.size() == 0, "R10", "missing writes", q_addr.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule